// File: doc/BRIEF.md
# Trap and Subroutine Control-Transfer Unit

This block works out the program-counter redirects and the link-register writes for a 16-bit register machine. It recognises four control-transfer words: a vectored system-call trap, a subroutine call with a PC-relative target, a subroutine call with a target held in a register, and a return through the link register (register 7). Every other word is accepted and has no effect. The block does not hold the register file or the memory. For the indirect call and the return it drives a register read address and uses the value that comes back in the same cycle. For a trap it reads one word from the vector table, which occupies the lowest 256 memory addresses. The index is the trap's 8-bit field, zero-extended.

Instruction words arrive on a valid/ready stream. A word transfers on a rising edge where both `insn_valid` and `insn_ready` are high. The sender must keep `insn`, `pc_inc` and `insn_valid` steady until that transfer happens. `pc_inc` is always the address of the instruction plus one. A trap takes two cycles. In the first cycle the unit issues the table read and holds `busy` high, which drops `insn_ready` and stalls fetch. In the second cycle it loads the returned word into the PC. Calls and returns finish one cycle after they are accepted. A privilege flag is set on every trap. A small frame tracker remembers whether each open frame was entered by a trap or by a call, so a return clears the flag only when it leaves the last trap frame.

Top module: `xfer_ctl`

## Requirements
- R1: After reset `pc_load`, `link_we`, `mem_req`, `busy` and `priv_mode` are 0 and `insn_ready` is 1.
- R2: A trap is a word with bits [15:12]=1111 and bits [11:8]=0000. In the cycle after it is accepted: `mem_req`=1, `mem_addr`={8'h00, insn[7:0]}, `busy`=1, `insn_ready`=0, `link_we`=1 and `link_data`=`pc_inc`.
- R3: In the cycle after the table read: `pc_load`=1, `pc_next` equals the `mem_rdata` presented during the read cycle, and `busy`=0, `mem_req`=0, `link_we`=0.
- R4: A relative call (bits [15:11]=01001), in the cycle after acceptance, gives `pc_load`=1, `pc_next`=`pc_inc`+sign-extended insn[10:0], `link_we`=1 and `link_data`=`pc_inc`.
- R5: A register call (bits [15:11]=01000, bits [10:9]=00, bits [5:0]=0) drives `rf_raddr`=insn[8:6] while offered. In the cycle after acceptance it gives `pc_load`=1, `pc_next`=`rf_data`, `link_we`=1 and `link_data`=`pc_inc`.
- R6: A return is exactly 16'hC1C0. It drives `rf_raddr`=7 while offered. In the cycle after acceptance it gives `pc_load`=1, `pc_next`=`rf_data` and `link_we`=0.
- R7: Any other word is accepted and gives no `pc_load`, `link_write` or `mem_req`, and `priv_mode` stays as it was. This covers a 1111 word with bits [11:8]≠0 and a 0100 word that breaks the R5 zero fields.
- R8: `priv_mode` is 1 from the cycle after a trap is accepted.
- R9: A return that closes a trap frame sets `priv_mode` to 1 if a trap frame is still open and to 0 otherwise. A return that closes a call frame leaves `priv_mode` unchanged.
- R10: A return with no open frame still jumps, and `priv_mode` is unchanged.
- R11: While `busy` is 1, `insn_ready` is 0. A word offered during that cycle is not taken and has no effect.
- R12: The tracker keeps the FRAME_DEPTH (default 4) most recent frames. A trap or call made when it is full discards the oldest frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit can take a word |
| insn | input | 16 | Instruction word |
| pc_inc | input | 16 | Address of the instruction plus one |
| rf_raddr | output | 3 | Register read address |
| rf_data | input | 16 | Register value for `rf_raddr` |
| mem_req | output | 1 | Vector-table read strobe |
| mem_addr | output | 16 | Vector-table read address |
| mem_rdata | input | 16 | Read data, valid while `mem_req` is high |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | 16 | Redirect target |
| link_we | output | 1 | Write `link_data` to register 7 |
| link_data | output | 16 | Return address |
| busy | output | 1 | Trap in progress; fetch stalls |
| priv_mode | output | 1 | Privileged execution flag |

## Verification
Two events can fall in the same cycle. The first is the trap's PC load together with a new word offered on the stream. The bench holds a word valid through every busy cycle and then checks that this cycle shows only the trap's redirect, with no link write. The second is a privilege change together with frame-tracker overflow. The bench nests more calls than FRAME_DEPTH inside traps and compares `priv_mode` after each return with a model stack that discards its oldest entries in the same way.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRAP,
    OP_CALL_REL,
    OP_CALL_REG,
    OP_RETURN
  } xfer_op_e;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_VEC
  } seq_state_e;
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned RA_W     = 3,
  parameter int unsigned LINK_IDX = 7,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned REL_W    = 11
) (
  input  logic [W-1:0]    insn_i,
  output xfer_op_e        op_o,
  output logic [RA_W-1:0] raddr_o,
  output logic [W-1:0]    rel_o,
  output logic [W-1:0]    vaddr_o
);
  localparam logic [W-1:0] RET_WORD = {4'hC, 3'b000, RA_W'(LINK_IDX), 6'b000000};

  logic [3:0] opc;
  logic       trap_hit, call_hit, reg_fields_ok;

  assign opc           = insn_i[W-1 -: 4];
  assign trap_hit      = (opc == 4'hF) && (insn_i[W-5 -: 4] == 4'h0);
  assign call_hit      = (opc == 4'h4);
  assign reg_fields_ok = (insn_i[10:9] == 2'b00) && (insn_i[5:0] == 6'd0);

  always_comb begin
    op_o = OP_NONE;
    if (trap_hit)                       op_o = OP_TRAP;
    else if (call_hit && insn_i[11])    op_o = OP_CALL_REL;
    else if (call_hit && reg_fields_ok) op_o = OP_CALL_REG;
    else if (insn_i == RET_WORD)        op_o = OP_RETURN;
  end

  assign raddr_o = (op_o == OP_RETURN) ? RA_W'(LINK_IDX) : insn_i[8:6];
  assign rel_o   = {{(W-REL_W){insn_i[REL_W-1]}}, insn_i[REL_W-1:0]};
  assign vaddr_o = {{(W-VEC_W){1'b0}}, insn_i[VEC_W-1:0]};
endmodule

// File: rtl/xfer_frame_track.sv
module xfer_frame_track #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic push_trap_i,
  input  logic pop_i,
  output logic priv_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] kind_q;
  logic [DEPTH-1:0] live;
  logic [CW-1:0]    cnt_q;
  logic             priv_q, full, rem_trap;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) live[i] = (CW'(i) < cnt_q);
  end

  assign full     = (cnt_q == CW'(DEPTH));
  assign rem_trap = |(kind_q[DEPTH-1:1] & live[DEPTH-1:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      cnt_q  <= '0;
      priv_q <= 1'b0;
    end else if (push_i) begin
      kind_q <= {kind_q[DEPTH-2:0], push_trap_i};
      if (!full) cnt_q <= cnt_q + CW'(1);
      if (push_trap_i) priv_q <= 1'b1;
    end else if (pop_i && (cnt_q != '0)) begin
      kind_q <= {1'b0, kind_q[DEPTH-1:1]};
      cnt_q  <= cnt_q - CW'(1);
      if (kind_q[0]) priv_q <= rem_trap;
    end
  end

  assign priv_o = priv_q;

  assert_depth_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_empty_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && cnt_q == '0) |=> $stable(priv_o));
  assert_call_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && cnt_q != '0 && !kind_q[0]) |=> $stable(priv_o));
endmodule

// File: rtl/xfer_ctl.sv
module xfer_ctl
  import xfer_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned RA_W        = 3,
  parameter int unsigned FRAME_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  output logic            insn_ready,
  input  logic [W-1:0]    insn,
  input  logic [W-1:0]    pc_inc,
  output logic [RA_W-1:0] rf_raddr,
  input  logic [W-1:0]    rf_data,
  output logic            mem_req,
  output logic [W-1:0]    mem_addr,
  input  logic [W-1:0]    mem_rdata,
  output logic            pc_load,
  output logic [W-1:0]    pc_next,
  output logic            link_we,
  output logic [W-1:0]    link_data,
  output logic            busy,
  output logic            priv_mode
);
  xfer_op_e   op;
  seq_state_e st_q;
  logic [W-1:0] rel, vaddr;
  logic accept, is_xfer_in, is_trap_in, is_ret_in;

  xfer_decode #(.W(W), .RA_W(RA_W), .LINK_IDX(7), .VEC_W(8), .REL_W(11)) u_dec (
    .insn_i (insn),
    .op_o   (op),
    .raddr_o(rf_raddr),
    .rel_o  (rel),
    .vaddr_o(vaddr)
  );

  assign busy       = (st_q == SEQ_VEC);
  assign insn_ready = !busy;
  assign accept     = insn_valid && insn_ready;
  assign is_trap_in = accept && (op == OP_TRAP);
  assign is_ret_in  = accept && (op == OP_RETURN);
  assign is_xfer_in = accept && (op == OP_TRAP || op == OP_CALL_REL || op == OP_CALL_REG);

  xfer_frame_track #(.DEPTH(FRAME_DEPTH)) u_frames (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (is_xfer_in),
    .push_trap_i(op == OP_TRAP),
    .pop_i      (is_ret_in),
    .priv_o     (priv_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_IDLE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      pc_load   <= 1'b0;
      pc_next   <= '0;
      link_we   <= 1'b0;
      link_data <= '0;
    end else begin
      pc_load <= 1'b0;
      link_we <= 1'b0;
      mem_req <= 1'b0;
      if (st_q == SEQ_VEC) begin
        pc_load <= 1'b1;
        pc_next <= mem_rdata;
        st_q    <= SEQ_IDLE;
      end else if (accept) begin
        unique case (op)
          OP_TRAP: begin
            st_q      <= SEQ_VEC;
            mem_req   <= 1'b1;
            mem_addr  <= vaddr;
            link_we   <= 1'b1;
            link_data <= pc_inc;
          end
          OP_CALL_REL: begin
            pc_load   <= 1'b1;
            pc_next   <= pc_inc + rel;
            link_we   <= 1'b1;
            link_data <= pc_inc;
          end
          OP_CALL_REG: begin
            pc_load   <= 1'b1;
            pc_next   <= rf_data;
            link_we   <= 1'b1;
            link_data <= pc_inc;
          end
          OP_RETURN: begin
            pc_load <= 1'b1;
            pc_next <= rf_data;
          end
          default: ;
        endcase
      end
    end
  end

  assert_vec_then_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (pc_load && !busy && !mem_req));
  assert_trap_link_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (link_we && busy));
  assert_trap_priv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_trap_in |=> priv_mode);
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_ret_no_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_ret_in |=> (pc_load && !link_we));
  assert_other_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_NONE) |=> (!pc_load && !link_we && !mem_req && $stable(priv_mode)));
endmodule

// File: tb/xfer_ctl_bench.sv
module xfer_ctl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic insn_valid = 1'b0;
  logic insn_ready;
  logic [15:0] insn = '0, pc_inc = '0, rf_data = '0, mem_rdata = '0;
  logic [2:0]  rf_raddr;
  logic mem_req, pc_load, link_we, busy, priv_mode;
  logic [15:0] mem_addr, pc_next, link_data;

  int total = 0, bad = 0;
  bit done = 0;

  logic [3:0] m_kind;
  int         m_cnt;
  logic       m_priv;

  always #4 clk = ~clk;

  xfer_ctl u_xfer_ctl (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn(insn), .pc_inc(pc_inc), .rf_raddr(rf_raddr), .rf_data(rf_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pc_load(pc_load), .pc_next(pc_next), .link_we(link_we), .link_data(link_data),
    .busy(busy), .priv_mode(priv_mode)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // 0 none, 1 trap, 2 rel call, 3 reg call, 4 return
  function automatic int classify(input logic [15:0] w);
    if (w[15:12] == 4'hF && w[11:8] == 4'h0) return 1;
    if (w[15:11] == 5'b01001) return 2;
    if (w[15:11] == 5'b01000 && w[10:9] == 2'b00 && w[5:0] == 6'd0) return 3;
    if (w == 16'hC1C0) return 4;
    return 0;
  endfunction

  function automatic logic [15:0] sx11(input logic [15:0] w);
    return {{5{w[10]}}, w[10:0]};
  endfunction

  task automatic m_push(input logic t);
    m_kind = {m_kind[2:0], t};
    if (m_cnt < 4) m_cnt++;
    if (t) m_priv = 1'b1;
  endtask

  task automatic m_pop();
    logic any;
    if (m_cnt == 0) return;
    any = 1'b0;
    for (int i = 1; i < m_cnt; i++) any = any | m_kind[i];
    if (m_kind[0]) m_priv = any;
    m_kind = {1'b0, m_kind[3:1]};
    m_cnt--;
  endtask

  // Called at a negedge. Ends at the negedge after the last output check.
  task automatic run_word(input logic [15:0] w, input logic [15:0] pc, input logic [15:0] rv,
                          input logic [15:0] vec_word, input logic [15:0] stall_word);
    int k;
    k = classify(w);
    insn = w; pc_inc = pc; rf_data = rv; insn_valid = 1'b1;
    #1;
    if (k == 3) chk("R5 rf_raddr", {13'd0, rf_raddr}, {13'd0, w[8:6]});
    if (k == 4) chk("R6 rf_raddr", {13'd0, rf_raddr}, 16'd7);
    @(negedge clk);
    if (k == 1) begin
      m_push(1'b1);
      chk("R2 mem_req", {15'd0, mem_req}, 16'd1);
      chk("R2 mem_addr", mem_addr, {8'h00, w[7:0]});
      chk("R2 busy/ready", {14'd0, busy, insn_ready}, 16'b10);
      chk("R2 link", {link_we, link_data[14:0]}, {1'b1, pc[14:0]});
      chk("R2 link msb", {15'd0, link_data[15]}, {15'd0, pc[15]});
      chk("R8 priv", {15'd0, priv_mode}, 16'd1);
      mem_rdata = vec_word;
      insn = stall_word; rf_data = ~rv;          // offered while busy: R11
      @(negedge clk);
      insn_valid = 1'b0;
      chk("R3 pc_load", {15'd0, pc_load}, 16'd1);
      chk("R3 pc_next", pc_next, vec_word);
      chk("R3/R11 quiet", {13'd0, busy, mem_req, link_we}, 16'd0);
      chk("R11 ready", {15'd0, insn_ready}, 16'd1);
      chk("R11 priv", {15'd0, priv_mode}, {15'd0, m_priv});
      mem_rdata = 16'h0;
    end else begin
      insn_valid = 1'b0;
      case (k)
        2: begin
          m_push(1'b0);
          chk("R4 pc", pc_next, pc + sx11(w));
          chk("R4 ctl", {14'd0, pc_load, link_we}, 16'b11);
          chk("R4 link", link_data, pc);
        end
        3: begin
          m_push(1'b0);
          chk("R5 pc", pc_next, rv);
          chk("R5 ctl", {14'd0, pc_load, link_we}, 16'b11);
          chk("R5 link", link_data, pc);
        end
        4: begin
          m_pop();
          chk("R6 pc", pc_next, rv);
          chk("R6 ctl", {14'd0, pc_load, link_we}, 16'b10);
        end
        default: begin
          chk("R7 quiet", {13'd0, pc_load, link_we, mem_req}, 16'd0);
        end
      endcase
      chk("R9 R12 priv", {15'd0, priv_mode}, {15'd0, m_priv});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed0;
    seed0 = $urandom(32'd4242);
    m_kind = '0; m_cnt = 0; m_priv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outs", {11'd0, pc_load, link_we, mem_req, busy, priv_mode}, 16'd0);
    chk("R1 ready", {15'd0, insn_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: return with nothing open
    run_word(16'hC1C0, 16'h3001, 16'h1234, 0, 0);
    // R7: near misses
    run_word(16'hF125, 16'h3002, 0, 0, 0);
    run_word(16'h4041, 16'h3003, 0, 0, 0);
    run_word(16'hC1C1, 16'h3004, 0, 0, 0);
    // R2/R3/R11 top vector, call offered while busy
    run_word(16'hF0FF, 16'h3005, 16'h0, 16'h0500, 16'h4FFF);
    // R4 extreme offsets
    run_word(16'h4C00, 16'h0500, 0, 0, 0);
    run_word(16'h4BFF, 16'hFFF0, 0, 0, 0);
    // R5 base reg 7
    run_word(16'h41C0, 16'h0800, 16'h0AAA, 0, 0);
    // R9 call return keeps priv, then trap returns
    run_word(16'hC1C0, 16'h0AAB, 16'h0801, 0, 0);
    run_word(16'hC1C0, 16'h0AAC, 16'h0800, 0, 0);
    run_word(16'hC1C0, 16'h0AAD, 16'h0502, 0, 0);
    run_word(16'hC1C0, 16'h0AAE, 16'h3006, 0, 0);
    // R12 overflow: trap then five calls then returns
    run_word(16'hF020, 16'h3007, 0, 16'h0600, 16'h0000);
    for (int i = 0; i < 5; i++) run_word(16'h4805, 16'h0600 + 16'(i), 0, 0, 0);
    for (int i = 0; i < 6; i++) run_word(16'hC1C0, 16'h0700, 16'h0601, 0, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [15:0] w;
      sel = $urandom_range(0, 9);
      if (sel < 2)      w = {8'hF0, 8'($urandom)};
      else if (sel < 4) w = {5'b01001, 11'($urandom)};
      else if (sel < 5) w = {7'b0100000, 3'($urandom), 6'd0};
      else if (sel < 8) w = 16'hC1C0;
      else begin
        w = 16'($urandom);
        while (classify(w) != 0) w = 16'($urandom);
      end
      run_word(w, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule